// File: doc/BRIEF.md
# Register-Triggered AXI4-Lite Transaction Engine

This block lets a small microcontroller with only a simple parallel peripheral bus reach an AXI4-Lite fabric without ever having to wait on AXI handshakes. Software loads a target address and, for writes, a data word into slave registers. It then writes a control word whose start bit launches exactly one AXI4-Lite read or write on the block's master port.

The engine takes a private copy of the address, data and direction when the start is accepted. It drives the address, write-data and response channels with their own valid/ready handshakes. When the response arrives, it records completion, the two-bit response code and, for reads, the returned word. Software polls a status register until the done flag is set and then reads the result at its own pace. The result stays put until the next accepted start.

Top module: `axil_cmd_bridge`

## Requirements
- R1: Host register offsets are fixed: 0x00 target address, 0x04 write data, 0x08 control, 0x0C status, 0x10 read data. The address and write-data registers read back what was last written. Control reads back the direction of the last accepted start in bit 1. Any other offset reads zero. A host read returns the register value on the clock edge where `host_rd` is sampled, and `host_rdata` holds it from then on.
- R2: While the engine is idle, a host write to control with bit 0 set is an accepted start. On the next clock edge it sets busy (status bit 0) and clears done (status bit 1). Control bit 1 gives the direction: 1 means write and 0 means read.
- R3: On an accepted write, `m_awvalid` and `m_wvalid` rise together one clock after the start. They carry the latched address and data, with `m_wstrb` all ones. Each valid stays high, with its payload stable, until its own ready is seen. The two drop independently of each other.
- R4: On an accepted read, `m_arvalid` rises one clock after the start with the latched address and holds until `m_arready`. No AW or W valid is raised during a read.
- R5: `m_bready` and `m_rready` are high exactly while busy, so a response is taken in the first cycle it is offered.
- R6: On the clock edge that completes the B or R handshake, the engine returns to idle. Status then shows busy=0, done=1, and bits [3:2] equal to the response code: 00 for OKAY, 10 for a slave error.
- R7: The read-data register (0x10) captures `m_rdata` on the R handshake. A write transaction leaves it unchanged.
- R8: A start written while busy is ignored. This includes a start landing on the same edge as the completing handshake. Writes to the address or write-data registers while busy do not alter the transaction in flight.
- R9: The done flag, the response field and the read-data register hold their values until the next accepted start, however late software polls.
- R10: After synchronous reset, all host registers read zero and every AXI valid and ready output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host register write strobe |
| host_rd | input | 1 | Host register read strobe |
| host_addr | input | HADDR_W | Host register byte offset |
| host_wdata | input | DATA_W | Host write data |
| host_rdata | output | DATA_W | Registered host read data |
| m_awaddr | output | AXI_AW | Write address |
| m_awvalid | output | 1 | Write address valid |
| m_awready | input | 1 | Write address ready |
| m_wdata | output | DATA_W | Write data |
| m_wstrb | output | DATA_W/8 | Write byte strobes |
| m_wvalid | output | 1 | Write data valid |
| m_wready | input | 1 | Write data ready |
| m_bresp | input | 2 | Write response code |
| m_bvalid | input | 1 | Write response valid |
| m_bready | output | 1 | Write response ready |
| m_araddr | output | AXI_AW | Read address |
| m_arvalid | output | 1 | Read address valid |
| m_arready | input | 1 | Read address ready |
| m_rdata | input | DATA_W | Read data |
| m_rresp | input | 2 | Read response code |
| m_rvalid | input | 1 | Read data valid |
| m_rready | output | 1 | Read data ready |

## Verification
Two pairs of events can fall on the same edge: a host access to the control or status register, and the B or R handshake that ends a transaction. The bench's slave model knows, one half-cycle ahead, that it will complete a response on the coming edge. The bench uses that moment to drive either a new start or a status read. A start on that edge must be ignored: status then shows done with no new address valid afterwards. A status read on that edge must still show busy with done clear, and the following read must show completion.

// File: rtl/axil_cmd_pkg.sv
package axil_cmd_pkg;

  // Host register byte offsets (software decodes these)
  localparam int OFF_ADDR  = 'h00;
  localparam int OFF_WDATA = 'h04;
  localparam int OFF_CTRL  = 'h08;
  localparam int OFF_STAT  = 'h0C;
  localparam int OFF_RDATA = 'h10;

  // Control and status bit positions
  localparam int CTRL_GO_BIT  = 0;
  localparam int CTRL_DIR_BIT = 1;
  localparam int STAT_BUSY    = 0;
  localparam int STAT_DONE    = 1;
  localparam int STAT_RESP_LO = 2;

  localparam logic [1:0] RESP_OKAY   = 2'b00;
  localparam logic [1:0] RESP_SLVERR = 2'b10;

  typedef enum logic [1:0] {
    ENG_IDLE  = 2'd0,
    ENG_WRITE = 2'd1,
    ENG_READ  = 2'd2
  } eng_state_e;

endpackage

// File: rtl/host_regfile.sv
module host_regfile
  import axil_cmd_pkg::*;
#(
  parameter int HADDR_W = 5,
  parameter int DATA_W  = 32,
  parameter int AXI_AW  = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               host_wr,
  input  logic               host_rd,
  input  logic [HADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0]  host_wdata,
  output logic [DATA_W-1:0]  host_rdata,
  input  logic               busy_i,
  input  logic               done_i,
  input  logic [1:0]         resp_i,
  input  logic [DATA_W-1:0]  rdata_i,
  output logic               start_o,
  output logic               dir_o,
  output logic [AXI_AW-1:0]  addr_o,
  output logic [DATA_W-1:0]  wdata_o
);

  localparam logic [HADDR_W-1:0] A_ADDR  = HADDR_W'(OFF_ADDR);
  localparam logic [HADDR_W-1:0] A_WDATA = HADDR_W'(OFF_WDATA);
  localparam logic [HADDR_W-1:0] A_CTRL  = HADDR_W'(OFF_CTRL);
  localparam logic [HADDR_W-1:0] A_STAT  = HADDR_W'(OFF_STAT);
  localparam logic [HADDR_W-1:0] A_RDATA = HADDR_W'(OFF_RDATA);

  logic [AXI_AW-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              dir_q;
  logic [DATA_W-1:0] stat_word;
  logic [DATA_W-1:0] rd_mux;

  // Start is accepted only when idle; direction is taken from the same write
  assign start_o = host_wr && (host_addr == A_CTRL) && host_wdata[CTRL_GO_BIT] && !busy_i;
  assign dir_o   = host_wdata[CTRL_DIR_BIT];
  assign addr_o  = addr_q;
  assign wdata_o = wdata_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q  <= '0;
      wdata_q <= '0;
      dir_q   <= 1'b0;
    end else begin
      if (host_wr && host_addr == A_ADDR)  addr_q  <= host_wdata[AXI_AW-1:0];
      if (host_wr && host_addr == A_WDATA) wdata_q <= host_wdata;
      if (start_o)                         dir_q   <= host_wdata[CTRL_DIR_BIT];
    end
  end

  always_comb begin
    stat_word = '0;
    stat_word[STAT_BUSY] = busy_i;
    stat_word[STAT_DONE] = done_i;
    stat_word[STAT_RESP_LO +: 2] = resp_i;
  end

  always_comb begin
    rd_mux = '0;
    case (host_addr)
      A_ADDR:  rd_mux = DATA_W'(addr_q);
      A_WDATA: rd_mux = wdata_q;
      A_CTRL:  rd_mux[CTRL_DIR_BIT] = dir_q;
      A_STAT:  rd_mux = stat_word;
      A_RDATA: rd_mux = rdata_i;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      host_rdata <= '0;
    end else if (host_rd) begin
      host_rdata <= rd_mux;
    end
  end

endmodule

// File: rtl/axil_txn_master.sv
module axil_txn_master
  import axil_cmd_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int AXI_AW = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start_i,
  input  logic                dir_i,
  input  logic [AXI_AW-1:0]   addr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic                busy_o,
  output logic                done_o,
  output logic [1:0]          resp_o,
  output logic [DATA_W-1:0]   rdata_o,
  output logic [AXI_AW-1:0]   m_awaddr,
  output logic                m_awvalid,
  input  logic                m_awready,
  output logic [DATA_W-1:0]   m_wdata,
  output logic [DATA_W/8-1:0] m_wstrb,
  output logic                m_wvalid,
  input  logic                m_wready,
  input  logic [1:0]          m_bresp,
  input  logic                m_bvalid,
  output logic                m_bready,
  output logic [AXI_AW-1:0]   m_araddr,
  output logic                m_arvalid,
  input  logic                m_arready,
  input  logic [DATA_W-1:0]   m_rdata,
  input  logic [1:0]          m_rresp,
  input  logic                m_rvalid,
  output logic                m_rready
);

  localparam int STRB_W = DATA_W / 8;

  eng_state_e        state_q;
  logic [AXI_AW-1:0] taddr_q;
  logic [DATA_W-1:0] twdata_q;
  logic              busy_q;

  assign busy_o   = busy_q;
  assign m_awaddr = taddr_q;
  assign m_araddr = taddr_q;
  assign m_wdata  = twdata_q;
  assign m_wstrb  = {STRB_W{1'b1}};
  assign m_bready = busy_q;
  assign m_rready = busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ENG_IDLE;
      busy_q    <= 1'b0;
      done_o    <= 1'b0;
      resp_o    <= RESP_OKAY;
      rdata_o   <= '0;
      taddr_q   <= '0;
      twdata_q  <= '0;
      m_awvalid <= 1'b0;
      m_wvalid  <= 1'b0;
      m_arvalid <= 1'b0;
    end else begin
      case (state_q)
        ENG_IDLE: begin
          if (start_i) begin
            busy_q  <= 1'b1;
            done_o  <= 1'b0;
            taddr_q <= addr_i;
            if (dir_i) begin
              twdata_q  <= wdata_i;
              m_awvalid <= 1'b1;
              m_wvalid  <= 1'b1;
              state_q   <= ENG_WRITE;
            end else begin
              m_arvalid <= 1'b1;
              state_q   <= ENG_READ;
            end
          end
        end
        ENG_WRITE: begin
          if (m_awvalid && m_awready) m_awvalid <= 1'b0;
          if (m_wvalid && m_wready)   m_wvalid  <= 1'b0;
          if (m_bvalid) begin
            resp_o  <= m_bresp;
            done_o  <= 1'b1;
            busy_q  <= 1'b0;
            state_q <= ENG_IDLE;
          end
        end
        ENG_READ: begin
          if (m_arvalid && m_arready) m_arvalid <= 1'b0;
          if (m_rvalid) begin
            rdata_o <= m_rdata;
            resp_o  <= m_rresp;
            done_o  <= 1'b1;
            busy_q  <= 1'b0;
            state_q <= ENG_IDLE;
          end
        end
        default: begin
          state_q <= ENG_IDLE;
          busy_q  <= 1'b0;
        end
      endcase
    end
  end

endmodule

// File: rtl/axil_cmd_bridge.sv
module axil_cmd_bridge
  import axil_cmd_pkg::*;
#(
  parameter int HADDR_W = 5,
  parameter int DATA_W  = 32,
  parameter int AXI_AW  = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                host_wr,
  input  logic                host_rd,
  input  logic [HADDR_W-1:0]  host_addr,
  input  logic [DATA_W-1:0]   host_wdata,
  output logic [DATA_W-1:0]   host_rdata,
  output logic [AXI_AW-1:0]   m_awaddr,
  output logic                m_awvalid,
  input  logic                m_awready,
  output logic [DATA_W-1:0]   m_wdata,
  output logic [DATA_W/8-1:0] m_wstrb,
  output logic                m_wvalid,
  input  logic                m_wready,
  input  logic [1:0]          m_bresp,
  input  logic                m_bvalid,
  output logic                m_bready,
  output logic [AXI_AW-1:0]   m_araddr,
  output logic                m_arvalid,
  input  logic                m_arready,
  input  logic [DATA_W-1:0]   m_rdata,
  input  logic [1:0]          m_rresp,
  input  logic                m_rvalid,
  output logic                m_rready
);

  logic              start_w;
  logic              dir_w;
  logic [AXI_AW-1:0] addr_w;
  logic [DATA_W-1:0] wdata_w;
  logic              busy_w;
  logic              done_w;
  logic [1:0]        resp_w;
  logic [DATA_W-1:0] rdata_w;

  host_regfile #(
    .HADDR_W(HADDR_W),
    .DATA_W (DATA_W),
    .AXI_AW (AXI_AW)
  ) u_regs (
    .clk       (clk),
    .rst       (rst),
    .host_wr   (host_wr),
    .host_rd   (host_rd),
    .host_addr (host_addr),
    .host_wdata(host_wdata),
    .host_rdata(host_rdata),
    .busy_i    (busy_w),
    .done_i    (done_w),
    .resp_i    (resp_w),
    .rdata_i   (rdata_w),
    .start_o   (start_w),
    .dir_o     (dir_w),
    .addr_o    (addr_w),
    .wdata_o   (wdata_w)
  );

  axil_txn_master #(
    .DATA_W(DATA_W),
    .AXI_AW(AXI_AW)
  ) u_eng (
    .clk      (clk),
    .rst      (rst),
    .start_i  (start_w),
    .dir_i    (dir_w),
    .addr_i   (addr_w),
    .wdata_i  (wdata_w),
    .busy_o   (busy_w),
    .done_o   (done_w),
    .resp_o   (resp_w),
    .rdata_o  (rdata_w),
    .m_awaddr (m_awaddr),
    .m_awvalid(m_awvalid),
    .m_awready(m_awready),
    .m_wdata  (m_wdata),
    .m_wstrb  (m_wstrb),
    .m_wvalid (m_wvalid),
    .m_wready (m_wready),
    .m_bresp  (m_bresp),
    .m_bvalid (m_bvalid),
    .m_bready (m_bready),
    .m_araddr (m_araddr),
    .m_arvalid(m_arvalid),
    .m_arready(m_arready),
    .m_rdata  (m_rdata),
    .m_rresp  (m_rresp),
    .m_rvalid (m_rvalid),
    .m_rready (m_rready)
  );

endmodule

// File: rtl/axil_cmd_bridge_chk.sv
module axil_cmd_bridge_chk
  import axil_cmd_pkg::*;
#(
  parameter int HADDR_W = 5,
  parameter int DATA_W  = 32,
  parameter int AXI_AW  = 32
) (
  input logic               clk,
  input logic               rst,
  input logic               host_wr,
  input logic [HADDR_W-1:0] host_addr,
  input logic [DATA_W-1:0]  host_wdata,
  input logic [AXI_AW-1:0]  m_awaddr,
  input logic               m_awvalid,
  input logic               m_awready,
  input logic [DATA_W-1:0]  m_wdata,
  input logic               m_wvalid,
  input logic               m_wready,
  input logic               m_bvalid,
  input logic               m_bready,
  input logic [AXI_AW-1:0]  m_araddr,
  input logic               m_arvalid,
  input logic               m_arready,
  input logic               m_rvalid,
  input logic               m_rready,
  input logic               busy,
  input logic               done,
  input logic [1:0]         resp
);

  logic ctrl_wr;
  assign ctrl_wr = host_wr && (host_addr == HADDR_W'(OFF_CTRL));

  // R2
  start_accept_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && ctrl_wr && host_wdata[CTRL_GO_BIT]) |=> (busy && !done));

  // R3
  aw_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (m_awvalid && !m_awready) |=> (m_awvalid && $stable(m_awaddr)));

  // R3
  w_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (m_wvalid && !m_wready) |=> (m_wvalid && $stable(m_wdata)));

  // R4
  ar_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (m_arvalid && !m_arready) |=> (m_arvalid && $stable(m_araddr)));

  // R4
  dir_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(m_arvalid && (m_awvalid || m_wvalid)));

  // R5
  ready_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (m_awvalid || m_wvalid || m_arvalid) |-> (m_bready && m_rready));

  // R6
  complete_chk: assert property (@(posedge clk) disable iff (rst)
    ((m_bvalid && m_bready) || (m_rvalid && m_rready)) |=> (done && !busy));

  // R8
  start_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && ctrl_wr) |=> ($stable(m_awaddr) && $stable(m_araddr)));

  // R9
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> (!done || $stable(resp)));

endmodule

bind axil_cmd_bridge axil_cmd_bridge_chk #(
  .HADDR_W(HADDR_W),
  .DATA_W (DATA_W),
  .AXI_AW (AXI_AW)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .host_wr   (host_wr),
  .host_addr (host_addr),
  .host_wdata(host_wdata),
  .m_awaddr  (m_awaddr),
  .m_awvalid (m_awvalid),
  .m_awready (m_awready),
  .m_wdata   (m_wdata),
  .m_wvalid  (m_wvalid),
  .m_wready  (m_wready),
  .m_bvalid  (m_bvalid),
  .m_bready  (m_bready),
  .m_araddr  (m_araddr),
  .m_arvalid (m_arvalid),
  .m_arready (m_arready),
  .m_rvalid  (m_rvalid),
  .m_rready  (m_rready),
  .busy      (busy_w),
  .done      (done_w),
  .resp      (resp_w)
);

// File: tb/tb_axil_cmd_bridge.sv
module tb_axil_cmd_bridge;

  localparam int HADDR_W = 5;
  localparam int DATA_W  = 32;
  localparam int AXI_AW  = 32;

  localparam logic [HADDR_W-1:0] O_ADDR  = 5'h00;
  localparam logic [HADDR_W-1:0] O_WDATA = 5'h04;
  localparam logic [HADDR_W-1:0] O_CTRL  = 5'h08;
  localparam logic [HADDR_W-1:0] O_STAT  = 5'h0C;
  localparam logic [HADDR_W-1:0] O_RDATA = 5'h10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic               host_wr = 1'b0;
  logic               host_rd = 1'b0;
  logic [HADDR_W-1:0] host_addr = '0;
  logic [DATA_W-1:0]  host_wdata = '0;
  logic [DATA_W-1:0]  host_rdata;
  logic [AXI_AW-1:0]  m_awaddr, m_araddr;
  logic               m_awvalid, m_wvalid, m_arvalid, m_bready, m_rready;
  logic [DATA_W-1:0]  m_wdata;
  logic [3:0]         m_wstrb;
  logic               m_awready = 1'b0, m_wready = 1'b0, m_arready = 1'b0;
  logic               m_bvalid = 1'b0, m_rvalid = 1'b0;
  logic [1:0]         m_bresp = 2'b00, m_rresp = 2'b00;
  logic [DATA_W-1:0]  m_rdata = '0;

  axil_cmd_bridge #(.HADDR_W(HADDR_W), .DATA_W(DATA_W), .AXI_AW(AXI_AW)) dut (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .m_awaddr(m_awaddr), .m_awvalid(m_awvalid), .m_awready(m_awready),
    .m_wdata(m_wdata), .m_wstrb(m_wstrb), .m_wvalid(m_wvalid), .m_wready(m_wready),
    .m_bresp(m_bresp), .m_bvalid(m_bvalid), .m_bready(m_bready),
    .m_araddr(m_araddr), .m_arvalid(m_arvalid), .m_arready(m_arready),
    .m_rdata(m_rdata), .m_rresp(m_rresp), .m_rvalid(m_rvalid), .m_rready(m_rready)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  // ---------------- slave model ----------------
  logic [31:0] smem [16];
  logic [31:0] ref_mem [16];
  bit pend_aw, pend_w, pend_ar, pend_b, pend_r;
  bit have_aw, have_w, have_ar;
  logic [31:0] cap_aw, cap_w, cap_ar;
  int aw_count = 0;

  function automatic logic [31:0] seed_word(int i);
    return 32'h1111_0000 + 32'(i) * 32'h0101;
  endfunction

  function automatic logic [31:0] err_word(logic [31:0] a);
    return 32'hBAD0_0000 | a;
  endfunction

  function automatic logic [1:0] exp_resp(logic [31:0] a);
    return a[6] ? 2'b10 : 2'b00;
  endfunction

  function automatic logic [31:0] exp_done_stat(logic [31:0] a);
    return {28'd0, exp_resp(a), 1'b1, 1'b0};
  endfunction

  initial begin
    for (int i = 0; i < 16; i++) begin
      smem[i] = seed_word(i);
      ref_mem[i] = seed_word(i);
    end
    forever begin
      @(negedge clk);
      if (rst) begin
        have_aw = 0; have_w = 0; have_ar = 0;
        pend_aw = 0; pend_w = 0; pend_ar = 0; pend_b = 0; pend_r = 0;
        m_awready = 0; m_wready = 0; m_arready = 0; m_bvalid = 0; m_rvalid = 0;
      end else begin
        if (pend_aw) begin have_aw = 1; aw_count++; end
        if (pend_w)  have_w = 1;
        if (pend_ar) have_ar = 1;
        if (pend_b)  m_bvalid = 0;
        if (pend_r)  m_rvalid = 0;
        if (have_aw && have_w && !m_bvalid && ($urandom % 3 != 0)) begin
          if (cap_aw[6]) m_bresp = 2'b10;
          else begin m_bresp = 2'b00; smem[cap_aw[5:2]] = cap_w; end
          m_bvalid = 1; have_aw = 0; have_w = 0;
        end
        if (have_ar && !m_rvalid && ($urandom % 3 != 0)) begin
          m_rresp = cap_ar[6] ? 2'b10 : 2'b00;
          m_rdata = cap_ar[6] ? err_word(cap_ar) : smem[cap_ar[5:2]];
          m_rvalid = 1; have_ar = 0;
        end
        m_awready = !have_aw && ($urandom % 2 == 0);
        m_wready  = !have_w  && ($urandom % 2 == 0);
        m_arready = !have_ar && ($urandom % 2 == 0);
        pend_aw = m_awvalid && m_awready;
        pend_w  = m_wvalid && m_wready;
        pend_ar = m_arvalid && m_arready;
        pend_b  = m_bvalid && m_bready;
        pend_r  = m_rvalid && m_rready;
        if (pend_aw) cap_aw = m_awaddr;
        if (pend_w)  cap_w  = m_wdata;
        if (pend_ar) cap_ar = m_araddr;
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // all host tasks start and end at negedge+1
  task automatic host_write(logic [HADDR_W-1:0] a, logic [31:0] d);
    host_wr = 1; host_addr = a; host_wdata = d;
    @(negedge clk); #1;
    host_wr = 0;
  endtask

  task automatic host_read(logic [HADDR_W-1:0] a, output logic [31:0] d);
    host_rd = 1; host_addr = a;
    @(negedge clk); #1;
    host_rd = 0;
    d = host_rdata;
  endtask

  task automatic wait_done(output logic [31:0] st);
    st = '0;
    for (int k = 0; k < 400; k++) begin
      host_read(O_STAT, st);
      if (st[1]) break;
    end
  endtask

  task automatic launch(logic [31:0] a, bit wr, logic [31:0] d);
    host_write(O_ADDR, a);
    host_write(O_WDATA, d);
    host_write(O_CTRL, {30'd0, wr, 1'b1});
  endtask

  task automatic run_txn(logic [31:0] a, bit wr, logic [31:0] d, string tag);
    logic [31:0] st, rd;
    launch(a, wr, d);
    wait_done(st);
    chk(st == exp_done_stat(a), {tag, " R6 status"}, st, exp_done_stat(a));
    if (wr && !a[6]) ref_mem[a[5:2]] = d;
    if (!wr) begin
      host_read(O_RDATA, rd);
      chk(rd == (a[6] ? err_word(a) : ref_mem[a[5:2]]), {tag, " R7 rdata"}, rd,
          a[6] ? err_word(a) : ref_mem[a[5:2]]);
    end
  endtask

  task automatic report;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      report();
    end
  end

  // ---------------- test flow ----------------
  initial begin
    logic [31:0] v, v2, keep;
    int seed_tmp;
    seed_tmp = $urandom(32'h5EED);
    repeat (4) @(posedge clk);
    @(negedge clk); #1;
    rst = 0;

    // R10 reset state
    chk(!m_awvalid && !m_wvalid && !m_arvalid && !m_bready && !m_rready, "R10 outputs idle",
        {27'd0, m_awvalid, m_wvalid, m_arvalid, m_bready, m_rready}, 0);
    host_read(O_STAT, v);  chk(v == 0, "R10 status", v, 0);
    host_read(O_RDATA, v); chk(v == 0, "R10 rdata", v, 0);
    host_read(O_ADDR, v);  chk(v == 0, "R10 addr", v, 0);

    // R1 register access
    host_write(O_ADDR, 32'h1234_5678);
    host_read(O_ADDR, v); chk(v == 32'h1234_5678, "R1 addr readback", v, 32'h1234_5678);
    host_write(O_WDATA, 32'hCAFE_F00D);
    host_read(O_WDATA, v); chk(v == 32'hCAFE_F00D, "R1 wdata readback", v, 32'hCAFE_F00D);
    host_read(5'h14, v); chk(v == 0, "R1 unmapped", v, 0);
    host_read(O_STAT, v); chk(v == 0, "R1 no start yet", v, 0);

    // R2/R3/R5 directed write
    launch(32'h0000_0008, 1'b1, 32'hA5A5_0001);
    chk(m_awvalid && m_wvalid && !m_arvalid, "R3 aw and w rise together",
        {29'd0, m_awvalid, m_wvalid, m_arvalid}, 32'h6);
    chk(m_awaddr == 32'h8 && m_wdata == 32'hA5A5_0001 && m_wstrb == 4'hF, "R3 payload",
        m_wdata, 32'hA5A5_0001);
    chk(m_bready && m_rready, "R5 readies while busy", {30'd0, m_bready, m_rready}, 3);
    host_read(O_STAT, v); chk(v == 32'h1, "R2 busy and done clear", v, 1);
    wait_done(v); chk(v == 32'h2, "R6 write okay", v, 2);
    ref_mem[2] = 32'hA5A5_0001;
    chk(!m_bready && !m_rready, "R5 readies low when idle", {30'd0, m_bready, m_rready}, 0);
    host_read(O_CTRL, v); chk(v == 32'h2, "R1 ctrl dir readback", v, 2);
    host_read(O_RDATA, v); chk(v == 0, "R7 write leaves rdata", v, 0);

    // R4 directed read
    launch(32'h0000_0008, 1'b0, 32'h0);
    chk(m_arvalid && !m_awvalid && !m_wvalid && m_araddr == 32'h8, "R4 ar only",
        {29'd0, m_awvalid, m_wvalid, m_arvalid}, 32'h1);
    wait_done(v); chk(v == 32'h2, "R6 read okay", v, 2);
    host_read(O_RDATA, v); chk(v == 32'hA5A5_0001, "R7 read data", v, 32'hA5A5_0001);
    host_read(O_CTRL, v); chk(v == 32'h0, "R1 ctrl dir read", v, 0);

    // R6 error responses
    run_txn(32'h0000_0044, 1'b1, 32'h7777_7777, "err write");
    run_txn(32'h0000_004C, 1'b0, 32'h0, "err read");

    // R8 start while busy ignored, register edits do not disturb flight
    launch(32'h0000_0010, 1'b1, 32'h0BEE_0010);
    host_write(O_ADDR, 32'h0000_0014);
    host_write(O_WDATA, 32'hDEAD_0014);
    host_write(O_CTRL, 32'h1);
    wait_done(v); chk(v == 32'h2, "R8 first txn result", v, 2);
    host_read(O_CTRL, v); chk(v == 32'h2, "R8 ignored start kept dir", v, 2);
    ref_mem[4] = 32'h0BEE_0010;
    run_txn(32'h0000_0010, 1'b0, 0, "R8 addr latched");
    run_txn(32'h0000_0014, 1'b0, 0, "R8 other addr untouched");

    // R8 start landing on the completion edge
    host_read(O_RDATA, keep);
    launch(32'h0000_0020, 1'b1, 32'h5151_0020);
    while (!pend_b) begin @(negedge clk); #1; end
    v2 = aw_count;
    host_write(O_CTRL, 32'h1);
    host_read(O_STAT, v); chk(v == 32'h2, "R8 same-edge start ignored", v, 2);
    repeat (4) begin
      chk(!m_arvalid && !m_awvalid, "R8 no new request", {30'd0, m_arvalid, m_awvalid}, 0);
      @(negedge clk); #1;
    end
    host_read(O_STAT, v); chk(v == 32'h2, "R9 status held", v, 2);
    host_read(O_RDATA, v); chk(v == keep, "R9 rdata held", v, keep);
    ref_mem[8] = 32'h5151_0020;

    // status read on the completion edge still sees busy
    launch(32'h0000_0024, 1'b1, 32'h6262_0024);
    while (!pend_b) begin @(negedge clk); #1; end
    host_read(O_STAT, v); chk(v == 32'h1, "R6 same-edge status read busy", v, 1);
    host_read(O_STAT, v); chk(v == 32'h2, "R6 next read done", v, 2);
    ref_mem[9] = 32'h6262_0024;

    // R9 late polling
    run_txn(32'h0000_0048, 1'b0, 0, "R9 err before wait");
    repeat (30) @(negedge clk); #1;
    host_read(O_STAT, v); chk(v == 32'hA, "R9 late poll error", v, 32'hA);
    host_read(O_RDATA, v); chk(v == err_word(32'h48), "R9 late rdata", v, err_word(32'h48));

    // random mix
    for (int n = 0; n < 60; n++) begin
      logic [31:0] a, d;
      bit wr;
      a = {25'd0, ($urandom % 4 == 0), 4'($urandom), 2'b00};
      d = $urandom;
      wr = ($urandom % 2 == 0);
      run_txn(a, wr, d, "rand");
    end

    finished = 1;
    report();
  end

endmodule